// File: doc/BRIEF.md
# ADC Conversion Command Sequencer

This block sits behind an SPI slave that has already assembled 16-bit command words. It watches for two command codes in the top nibble. One is an ADC write that carries the whole converter setup: power mode, acquisition source, input type, polarity and channel. The other is a result read. An ADC write always replaces the complete converter configuration. When its power mode is one of the two powered modes, the write also launches a conversion on an external successive-approximation converter. The block reports busy from acceptance until the converter signals completion.

The converter side is reduced to a one-cycle start strobe, a configuration bus and a done strobe that carries 12 bits of data. Software polls busy, waits for it to drop, and then issues a read. The read returns the held result in the low 12 bits of the response word. An ADC write that arrives while a conversion is in progress is dropped, and a sticky error flag records it.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: After synchronous reset, busy, cmd_err, adc_start and rsp_valid are 0, and adc_cfg and rsp_data are 0.
- R2: An accepted write (cmd_word[15:12] = 4'h4) copies cmd_word[7:0] in full onto adc_cfg one cycle later. The bit layout is power mode [7:6] (00 off, 01 standby, 10 on with internal clock, 11 on with external clock), external acquisition [5], single-ended [4], unipolar [3] and channel [2:0].
- R3: An accepted write with power mode 10 or 11 sets busy and produces adc_start high for exactly one cycle, both visible in the cycle after the command.
- R4: An accepted write with power mode 00 or 01 updates adc_cfg but produces no adc_start, and busy stays low.
- R5: Busy stays high until an adc_done pulse. In the cycle after that pulse, busy is low and adc_data has been captured as the new result.
- R6: An ADC write while busy is high is ignored: adc_cfg is unchanged and there is no further adc_start. It also sets cmd_err, which stays high until reset.
- R7: A read command (cmd_word[15:12] = 4'hB) gives rsp_valid high for one cycle, in the cycle after the command, with rsp_data = {4'b0000, result}.
- R8: The result is held until the next conversion completes. An adc_done pulse while busy is low does not change it.
- R9: Any other command code leaves busy, cmd_err, adc_cfg, adc_start and rsp_valid unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Decoded SPI command word |
| busy | output | 1 | Conversion in progress |
| cmd_err | output | 1 | Sticky flag: write dropped while busy |
| adc_start | output | 1 | One-cycle conversion start to the converter |
| adc_cfg | output | 8 | Latched converter configuration |
| adc_done | input | 1 | Converter completion strobe |
| adc_data | input | 12 | Conversion value, valid with adc_done |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 16 | Read response word |

## Verification
The bench probes several corner cases:
- Writes in power-down and standby mode. A design that treated any write as a conversion would raise busy and wait forever for a done pulse.
- A fully set configuration word followed by one with most bits clear. A design that merged fields would keep stale bits.
- A write during a conversion. A design that did not guard it would restart the converter or corrupt the configuration.
- A stray done pulse and unknown command codes. A design that captured data outside a conversion, or decoded too few bits, would overwrite the held result or the configuration.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CMD_W  = 16;
  localparam int CODE_W = 4;
  localparam int CH_W   = 3;
  localparam int CFG_W  = CH_W + 5;
  localparam int RES_W  = 12;
  localparam logic [CODE_W-1:0] CODE_ADC_WR = 4'h4;
  localparam logic [CODE_W-1:0] CODE_ADC_RD = 4'hB;
endpackage

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
  import adc_seq_pkg::*;
#(
  parameter int CW = CMD_W,
  parameter int KW = CODE_W,
  parameter int FW = CFG_W
) (
  input  logic          cmd_valid,
  input  logic [CW-1:0] cmd_word,
  output logic          wr_req,
  output logic          rd_req,
  output logic          powered,
  output logic [FW-1:0] cfg_word
);
  logic [KW-1:0] code;
  assign code     = cmd_word[CW-1 -: KW];
  assign wr_req   = cmd_valid && (code == CODE_ADC_WR);
  assign rd_req   = cmd_valid && (code == CODE_ADC_RD);
  assign cfg_word = cmd_word[FW-1:0];
  // top bit of the power-mode field marks the two powered modes
  assign powered  = cmd_word[FW-1];
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          powered,
  input  logic [FW-1:0] cfg_word,
  input  logic          adc_done,
  output logic          busy,
  output logic          adc_start,
  output logic [FW-1:0] adc_cfg,
  output logic          cmd_err,
  output logic          capture
);
  assign capture = busy && adc_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      adc_start <= 1'b0;
      adc_cfg   <= '0;
      cmd_err   <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      if (wr_req) begin
        if (busy) begin
          cmd_err <= 1'b1;
        end else begin
          adc_cfg <= cfg_word;
          if (powered) begin
            busy      <= 1'b1;
            adc_start <= 1'b1;
          end
        end
      end
      if (capture) busy <= 1'b0;
    end
  end

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> busy);
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !adc_done) |=> busy);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> cmd_err);
  // R6
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(adc_cfg));
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int RW = 12,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [RW-1:0] adc_data,
  input  logic          rd_req,
  output logic          rsp_valid,
  output logic [CW-1:0] rsp_data
);
  localparam int PAD_W = CW - RW;
  logic [RW-1:0] result_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= {{PAD_W{1'b0}}, result_q};
      if (capture) result_q <= adc_data;
    end
  end

  // R7
  rsp_pad_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_data[CW-1:RW] == '0));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(result_q));
endmodule

// File: rtl/adc_cmd_sequencer.sv
module adc_cmd_sequencer
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             busy,
  output logic             cmd_err,
  output logic             adc_start,
  output logic [CFG_W-1:0] adc_cfg,
  input  logic             adc_done,
  input  logic [RES_W-1:0] adc_data,
  output logic             rsp_valid,
  output logic [CMD_W-1:0] rsp_data
);
  logic             wr_req, rd_req, powered, capture;
  logic [CFG_W-1:0] cfg_word;

  adc_cmd_decode #(.CW(CMD_W), .KW(CODE_W), .FW(CFG_W)) u_dec (
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .wr_req(wr_req),
    .rd_req(rd_req), .powered(powered), .cfg_word(cfg_word)
  );

  adc_conv_ctrl #(.FW(CFG_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_req(wr_req), .powered(powered),
    .cfg_word(cfg_word), .adc_done(adc_done), .busy(busy),
    .adc_start(adc_start), .adc_cfg(adc_cfg), .cmd_err(cmd_err),
    .capture(capture)
  );

  adc_result_hold #(.RW(RES_W), .CW(CMD_W)) u_res (
    .clk(clk), .rst(rst), .capture(capture), .adc_data(adc_data),
    .rd_req(rd_req), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: tb/adc_cmd_sequencer_tb.sv
module adc_cmd_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        busy, cmd_err, adc_start, rsp_valid;
  logic [7:0]  adc_cfg;
  logic        adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic [15:0] rsp_data;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_cmd_sequencer u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .busy(busy), .cmd_err(cmd_err), .adc_start(adc_start), .adc_cfg(adc_cfg),
    .adc_done(adc_done), .adc_data(adc_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  // {cfg byte, conversion value}
  localparam logic [19:0] VEC [6] = '{
    {8'h9A, 12'hA5C}, {8'hC7, 12'hFFF}, {8'h40, 12'h111},
    {8'h85, 12'h000}, {8'h3F, 12'h222}, {8'hE1, 12'h123}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk); cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk); cmd_valid = 1'b0; cmd_word = '0;
  endtask

  task automatic finish_conv(input logic [11:0] d);
    @(negedge clk); adc_done = 1'b1; adc_data = d;
    @(negedge clk); adc_done = 1'b0; adc_data = '0;
  endtask

  task automatic read_chk(input logic [11:0] exp, input string tag);
    send(16'hB000);
    chk(rsp_valid == 1'b1, tag, rsp_valid, 1);
    chk(rsp_data == {4'h0, exp}, tag, rsp_data, {4'h0, exp});
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 rsp one cycle", rsp_valid, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [11:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !cmd_err && !adc_start && !rsp_valid, "R1 flags", {busy, cmd_err, adc_start, rsp_valid}, 0);
    chk(adc_cfg == 8'h00 && rsp_data == 16'h0, "R1 cfg/rsp", adc_cfg, 0);

    held = 12'h000;
    for (int i = 0; i < 6; i++) begin
      logic [7:0]  c;
      logic [11:0] d;
      c = VEC[i][19:12];
      d = VEC[i][11:0];
      send({8'h40, c});
      chk(adc_cfg == c, "R2 cfg latched", adc_cfg, c);
      if (c[7]) begin
        chk(busy && adc_start, "R3 busy+start", {busy, adc_start}, 3);
        repeat (2) @(negedge clk);
        chk(busy && !adc_start, "R5 busy held, start single", {busy, adc_start}, 2);
        finish_conv(d);
        chk(!busy, "R5 busy drops after done", busy, 0);
        held = d;
      end else begin
        chk(!busy && !adc_start, "R4 no conversion", {busy, adc_start}, 0);
        @(negedge clk);
        chk(!busy && !adc_start, "R4 still idle", {busy, adc_start}, 0);
      end
      read_chk(held, "R7 read result");
    end

    // R6: write while busy
    send(16'h4081);
    chk(busy && adc_cfg == 8'h81, "R3 start conv", adc_cfg, 8'h81);
    send(16'h40DE);
    chk(adc_cfg == 8'h81, "R6 cfg unchanged", adc_cfg, 8'h81);
    chk(!adc_start, "R6 no restart", adc_start, 0);
    chk(cmd_err, "R6 err set", cmd_err, 1);
    finish_conv(12'h7E4);
    chk(!busy, "R5 busy cleared", busy, 0);
    chk(cmd_err, "R6 err sticky", cmd_err, 1);
    read_chk(12'h7E4, "R7 read after busy case");

    // R8: stray done while idle
    finish_conv(12'h999);
    read_chk(12'h7E4, "R8 stray done ignored");

    // R9: unknown codes
    send(16'h80C3);
    chk(!busy && !adc_start && !rsp_valid && adc_cfg == 8'h81, "R9 code 8 ignored", adc_cfg, 8'h81);
    send(16'hC0FF);
    chk(!busy && !rsp_valid && adc_cfg == 8'h81, "R9 code C ignored", adc_cfg, 8'h81);
    read_chk(12'h7E4, "R9 result intact");

    // R1: reset clears sticky error
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!cmd_err && adc_cfg == 8'h00, "R1 reset clears", {cmd_err, adc_cfg}, 0);
    read_chk(12'h000, "R1 result reset");

    summary();
  end
endmodule